// File: doc/BRIEF.md
# Half-Bridge Gate Driver Fault Protection Manager

This block sits between the raw protection comparators of a two-channel half-bridge gate driver and its interlock logic. Each side (high and low) has four shutdown-class inputs: desaturation, overcurrent, overtemperature shutdown and gate-integrity. Each side also has one overtemperature warning input. Every input must persist for a qualification time before it counts. The desaturation and overcurrent inputs are also ignored during a blanking window that follows a switching-edge strobe on the same side.

A qualified shutdown trip raises `fault_active`, which forces both gate outputs safe, and captures a report. The report gives the side (high, low or both) and the highest-priority fault class. Every source seen is also collected in a sticky status vector. Recovery follows one of two policies. In the latched policy, a clear pulse is required. In the auto-retry policy, the block re-enables after a quiet backoff window, up to a fixed number of retries, after which it latches. An overtemperature cause always needs a longer cool-down before release. Warnings are reported but never shut the bridge down.

Top module: `gfm_fault_mgr`

## Requirements
- R1: A protection input takes effect only after it has been high for QUAL_CYC (default 4) consecutive clock cycles. A shorter pulse causes no trip and no sticky bit.
- R2: A qualified shutdown input while idle sets `fault_active` on the following clock edge, and `gate_ok` goes low with it.
- R3: While `fault_active` is high, `rpt_side` and `rpt_class` hold the values captured at the trip. `rpt_side` bit 0 marks the high side and bit 1 the low side (11 means both). `rpt_class` codes are 1 desaturation, 2 overcurrent, 3 overtemperature and 4 integrity. Both fields read 0 when idle.
- R4: When several sources qualify together, the class reported is the first present in the order desaturation, overcurrent, overtemperature, integrity.
- R5: `src_sticky` bits [3:0] record qualified high-side sources and bits [7:4] record low-side sources. Within each nibble, bit 0 is desaturation, bit 1 overcurrent, bit 2 overtemperature and bit 3 integrity. The same bit order applies to `prot_hi` and `prot_lo`. An accepted clear empties the vector.
- R6: A switching-edge strobe on one side blanks that side's desaturation and overcurrent inputs for BLANK_CYC (default 6) cycles. A pulse lying inside that window causes no trip.
- R7: A qualified overtemperature warning sets the matching `ot_warn` bit (bit 0 high, bit 1 low) and never raises `fault_active`.
- R8: With `auto_retry` low, a fault stays active until a rising edge on `clr_pin`. A clear edge is ignored while any raw shutdown input is still high.
- R9: With `auto_retry` high, a non-thermal fault releases by itself once the raw shutdown inputs have been low for BACKOFF_CYC (default 20) cycles.
- R10: Auto-retry releases are capped at MAX_RETRY (default 2). The next fault latches until an accepted clear, and that clear restores the retry budget.
- R11: A fault caused by overtemperature is not released, by clear or by retry, until the raw inputs have been low for COOL_CYC (default 50) cycles.
- R12: `gate_ok` is high only when `en` and `supply_ok` are high and no fault is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_retry | input | 1 | 1 selects the auto-retry policy, 0 the latched policy |
| en | input | 1 | Driver enable |
| supply_ok | input | 1 | Rails and isolation link valid |
| clr_pin | input | 1 | Fault clear request; acts on its rising edge |
| sw_edge_hi | input | 1 | High-side switching-edge strobe that starts blanking |
| sw_edge_lo | input | 1 | Low-side switching-edge strobe that starts blanking |
| prot_hi | input | 4 | High-side raw shutdown inputs {integ, ot, oc, desat} |
| prot_lo | input | 4 | Low-side raw shutdown inputs {integ, ot, oc, desat} |
| warn_hi | input | 1 | High-side raw overtemperature warning |
| warn_lo | input | 1 | Low-side raw overtemperature warning |
| fault_active | output | 1 | Fault state; blocks PWM in the interlock |
| gate_ok | output | 1 | Outputs may follow PWM |
| rpt_side | output | 2 | Reported fault side |
| rpt_class | output | 3 | Reported fault class code |
| ot_warn | output | 2 | Qualified overtemperature warnings {lo, hi} |
| src_sticky | output | 8 | Sticky record of qualified sources |

## Verification
A corrupted persistence or blanking counter shows as `fault_active` rising early, late or not at all. The bench checks this one cycle past the expected qualification edge. A wrong priority or side capture appears at once in `rpt_class` and `rpt_side` on the trip edge, and stays visible while the fault is held. Errors in the retry counter or the quiet timer are more latent. They show only as a release that comes too early, too late, or after the cap, so the bench walks a fault through repeated retries and checks release windows with a few cycles of margin.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
   typedef enum logic [2:0] {
      CLS_NONE  = 3'd0,
      CLS_DESAT = 3'd1,
      CLS_OC    = 3'd2,
      CLS_OT    = 3'd3,
      CLS_INTEG = 3'd4
   } flt_cls_e;

   localparam int NSRC   = 4;   // shutdown sources per side
   localparam int SRC_OT = 2;   // index of overtemperature in a source nibble

   typedef enum logic {ST_RUN = 1'b0, ST_TRIP = 1'b1} pol_state_e;
endpackage

// File: rtl/gfm_qual.sv
module gfm_qual #(
   parameter int QUAL_CYC  = 4,
   parameter int BLANK_CYC = 6,
   parameter bit USE_BLANK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic sw_edge,
   output logic qual
);
   localparam int CW = $clog2(QUAL_CYC + 1);
   localparam int BW = $clog2(BLANK_CYC + 1);

   logic [CW-1:0] cnt;
   logic          blanked;

   generate
      if (USE_BLANK) begin : g_blank
         logic [BW-1:0] bcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              bcnt <= '0;
            else if (sw_edge)        bcnt <= BW'(BLANK_CYC);
            else if (bcnt != '0)     bcnt <= bcnt - 1'b1;
         end
         assign blanked = sw_edge | (bcnt != '0);
      end else begin : g_noblank
         logic unused_edge;
         assign unused_edge = sw_edge;
         assign blanked     = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (!raw || blanked)       cnt <= '0;
      else if (cnt != CW'(QUAL_CYC))  cnt <= cnt + 1'b1;
   end

   assign qual = (cnt == CW'(QUAL_CYC));

   AST_QUAL_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qual) |-> $past(raw)); // R1
endmodule

// File: rtl/gfm_prio.sv
module gfm_prio
   import gfm_pkg::*;
(
   input  logic [1:0][NSRC-1:0] q,
   output flt_cls_e             cls,
   output logic [1:0]           side
);
   logic [NSRC-1:0] any_src;

   always_comb begin
      any_src = q[0] | q[1];
      cls     = CLS_NONE;
      for (int k = NSRC - 1; k >= 0; k--) begin
         if (any_src[k]) cls = flt_cls_e'(3'(k + 1));
      end
      side = {|q[1], |q[0]};
   end
endmodule

// File: rtl/gfm_policy.sv
module gfm_policy
   import gfm_pkg::*;
#(
   parameter int BACKOFF_CYC = 20,
   parameter int COOL_CYC    = 50,
   parameter int MAX_RETRY   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_retry,
   input  logic clr_pin,
   input  logic trip_any,
   input  logic trip_ot,
   input  logic raw_any,
   output logic flt_active,
   output logic capture,
   output logic release_ev,
   output logic clr_ok
);
   localparam int QW = $clog2(COOL_CYC + 1);
   localparam int RW = $clog2(MAX_RETRY + 1);

   pol_state_e    state;
   logic [QW-1:0] quiet_cnt;
   logic [QW-1:0] need;
   logic [RW-1:0] retry_cnt;
   logic          ot_cause, clr_q, clr_rise, capped, quiet_ok, auto_rel;

   assign clr_rise = clr_pin & ~clr_q;
   assign capped   = (retry_cnt == RW'(MAX_RETRY));

   always_comb begin
      if (ot_cause)                   need = QW'(COOL_CYC);
      else if (auto_retry && !capped) need = QW'(BACKOFF_CYC);
      else                            need = '0;
   end

   assign quiet_ok   = !raw_any && !trip_any && (quiet_cnt >= need);
   assign clr_ok     = clr_rise && !raw_any && (state == ST_RUN || quiet_ok);
   assign auto_rel   = (state == ST_TRIP) && auto_retry && !capped && quiet_ok;
   assign capture    = (state == ST_RUN) && trip_any;
   assign release_ev = (state == ST_TRIP) && (auto_rel || clr_ok);
   assign flt_active = (state == ST_TRIP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_RUN;
         quiet_cnt <= '0;
         retry_cnt <= '0;
         ot_cause  <= 1'b0;
         clr_q     <= 1'b0;
      end else begin
         clr_q <= clr_pin;
         if (state == ST_RUN) begin
            if (clr_ok) retry_cnt <= '0;
            if (trip_any) begin
               state     <= ST_TRIP;
               quiet_cnt <= '0;
               ot_cause  <= trip_ot;
            end
         end else begin
            if (trip_ot) ot_cause <= 1'b1;
            if (raw_any)                         quiet_cnt <= '0;
            else if (quiet_cnt != QW'(COOL_CYC)) quiet_cnt <= quiet_cnt + 1'b1;
            if (auto_rel) begin
               state     <= ST_RUN;
               retry_cnt <= retry_cnt + 1'b1;
               ot_cause  <= 1'b0;
            end else if (clr_ok) begin
               state     <= ST_RUN;
               retry_cnt <= '0;
               ot_cause  <= 1'b0;
            end
         end
      end
   end

   AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      retry_cnt <= RW'(MAX_RETRY)); // R10
   AST_HOLD_WHILE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_active && raw_any) |=> flt_active); // R8
   AST_OT_COOL: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_active && ot_cause && quiet_cnt < QW'(COOL_CYC)) |=> flt_active); // R11
endmodule

// File: rtl/gfm_fault_mgr.sv
module gfm_fault_mgr
   import gfm_pkg::*;
#(
   parameter int QUAL_CYC    = 4,
   parameter int BLANK_CYC   = 6,
   parameter int BACKOFF_CYC = 20,
   parameter int COOL_CYC    = 50,
   parameter int MAX_RETRY   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       auto_retry,
   input  logic       en,
   input  logic       supply_ok,
   input  logic       clr_pin,
   input  logic       sw_edge_hi,
   input  logic       sw_edge_lo,
   input  logic [3:0] prot_hi,
   input  logic [3:0] prot_lo,
   input  logic       warn_hi,
   input  logic       warn_lo,
   output logic       fault_active,
   output logic       gate_ok,
   output logic [1:0] rpt_side,
   output logic [2:0] rpt_class,
   output logic [1:0] ot_warn,
   output logic [7:0] src_sticky
);
   generate
      if (QUAL_CYC < 1 || BLANK_CYC < 1 || BACKOFF_CYC < 1 ||
          COOL_CYC < BACKOFF_CYC || MAX_RETRY < 1) begin : g_param_bad
         $error("gfm_fault_mgr: illegal timing parameters");
      end
   endgenerate

   logic [1:0][NSRC-1:0] raw_s, q_s;
   logic [1:0]           edge_s, warn_raw;
   flt_cls_e             cls;
   logic [1:0]           side;
   logic                 trip_any, trip_ot, raw_any, capture, release_ev, clr_ok;

   assign raw_s[0]  = prot_hi;
   assign raw_s[1]  = prot_lo;
   assign edge_s    = {sw_edge_lo, sw_edge_hi};
   assign warn_raw  = {warn_lo, warn_hi};

   for (genvar s = 0; s < 2; s++) begin : g_side
      for (genvar k = 0; k < NSRC; k++) begin : g_src
         gfm_qual #(.QUAL_CYC(QUAL_CYC), .BLANK_CYC(BLANK_CYC),
                    .USE_BLANK(k < SRC_OT)) u_q (
            .clk(clk), .rst_n(rst_n), .raw(raw_s[s][k]),
            .sw_edge(edge_s[s]), .qual(q_s[s][k]));
      end
      gfm_qual #(.QUAL_CYC(QUAL_CYC), .BLANK_CYC(BLANK_CYC),
                 .USE_BLANK(1'b0)) u_warn (
         .clk(clk), .rst_n(rst_n), .raw(warn_raw[s]),
         .sw_edge(1'b0), .qual(ot_warn[s]));
   end

   assign trip_any = |q_s;
   assign trip_ot  = q_s[0][SRC_OT] | q_s[1][SRC_OT];
   assign raw_any  = |raw_s;

   gfm_prio u_prio (.q(q_s), .cls(cls), .side(side));

   gfm_policy #(.BACKOFF_CYC(BACKOFF_CYC), .COOL_CYC(COOL_CYC),
                .MAX_RETRY(MAX_RETRY)) u_pol (
      .clk(clk), .rst_n(rst_n), .auto_retry(auto_retry), .clr_pin(clr_pin),
      .trip_any(trip_any), .trip_ot(trip_ot), .raw_any(raw_any),
      .flt_active(fault_active), .capture(capture),
      .release_ev(release_ev), .clr_ok(clr_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rpt_side   <= '0;
         rpt_class  <= '0;
         src_sticky <= '0;
      end else begin
         if (capture) begin
            rpt_side  <= side;
            rpt_class <= cls;
         end else if (release_ev) begin
            rpt_side  <= '0;
            rpt_class <= '0;
         end
         if (clr_ok) src_sticky <= '0;
         else        src_sticky <= src_sticky | {q_s[1], q_s[0]};
      end
   end

   assign gate_ok = en & supply_ok & ~fault_active;

   AST_TRIP_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_active && trip_any) |=> (fault_active && !gate_ok)); // R2
   AST_REPORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_active && $past(fault_active)) |-> ($stable(rpt_class) && rpt_class != 3'd0)); // R3
   AST_WARN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_active && !trip_any && |ot_warn) |=> !fault_active); // R7
endmodule

// File: tb/sim_gfm_fault_mgr.sv
module sim_gfm_fault_mgr;
   localparam int QUAL    = 4;
   localparam int BLANK   = 6;
   localparam int BACKOFF = 20;
   localparam int COOL    = 50;
   localparam int MAXR    = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic auto_retry = 1'b0, en = 1'b0, supply_ok = 1'b0, clr_pin = 1'b0;
   logic sw_edge_hi = 1'b0, sw_edge_lo = 1'b0;
   logic [3:0] prot_hi = '0, prot_lo = '0;
   logic warn_hi = 1'b0, warn_lo = 1'b0;
   logic fault_active, gate_ok;
   logic [1:0] rpt_side, ot_warn;
   logic [2:0] rpt_class;
   logic [7:0] src_sticky;
   int checks = 0, failures = 0;

   always #4 clk = ~clk;

   gfm_fault_mgr #(.QUAL_CYC(QUAL), .BLANK_CYC(BLANK), .BACKOFF_CYC(BACKOFF),
                   .COOL_CYC(COOL), .MAX_RETRY(MAXR)) u0 (
      .clk(clk), .rst_n(rst_n), .auto_retry(auto_retry), .en(en),
      .supply_ok(supply_ok), .clr_pin(clr_pin), .sw_edge_hi(sw_edge_hi),
      .sw_edge_lo(sw_edge_lo), .prot_hi(prot_hi), .prot_lo(prot_lo),
      .warn_hi(warn_hi), .warn_lo(warn_lo), .fault_active(fault_active),
      .gate_ok(gate_ok), .rpt_side(rpt_side), .rpt_class(rpt_class),
      .ot_warn(ot_warn), .src_sticky(src_sticky));

   // {prot_hi, prot_lo, expected side, expected class}
   localparam logic [12:0] VEC [0:6] = '{
      {4'b0001, 4'b0000, 2'b01, 3'd1},
      {4'b0000, 4'b0010, 2'b10, 3'd2},
      {4'b1000, 4'b0000, 2'b01, 3'd4},
      {4'b0010, 4'b0001, 2'b11, 3'd1},
      {4'b0011, 4'b0000, 2'b01, 3'd1},
      {4'b0000, 4'b1010, 2'b10, 3'd2},
      {4'b1000, 4'b0010, 2'b11, 3'd2}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_clr();
      clr_pin = 1'b1; tick(1); clr_pin = 1'b0; tick(1);
   endtask

   initial begin
      #(8 * 150000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      tick(3);
      chk("R3 reset class", {29'd0, rpt_class}, 0);
      chk("R5 reset sticky", {24'd0, src_sticky}, 0);
      chk("R12 reset gate", {31'd0, gate_ok}, 0);
      rst_n = 1'b1; tick(2);
      chk("R2 reset idle", {31'd0, fault_active}, 0);

      // R12 gating by enable and validity
      en = 1'b1; tick(1);
      chk("R12 en only", {31'd0, gate_ok}, 0);
      supply_ok = 1'b1; tick(1);
      chk("R12 en and supply", {31'd0, gate_ok}, 1);

      // Table walk, latched policy: R3 R4 R5 R8
      for (int i = 0; i < 7; i++) begin
         prot_hi = VEC[i][12:9]; prot_lo = VEC[i][8:5];
         tick(QUAL);
         chk("R1 not before qual", {31'd0, fault_active}, 0);
         tick(2);
         chk("R2 trip", {30'd0, fault_active, gate_ok}, 2'b10);
         chk("R3 side", {30'd0, rpt_side}, {30'd0, VEC[i][4:3]});
         chk("R4 class", {29'd0, rpt_class}, {29'd0, VEC[i][2:0]});
         chk("R5 sticky", {24'd0, src_sticky}, {24'd0, VEC[i][8:5], VEC[i][12:9]});
         pulse_clr(); tick(1);
         chk("R8 clear ignored while raw", {31'd0, fault_active}, 1);
         prot_hi = '0; prot_lo = '0; tick(3);
         chk("R8 held without clear", {31'd0, fault_active}, 1);
         pulse_clr(); tick(1);
         chk("R8 released by clear", {31'd0, fault_active}, 0);
         chk("R3 idle report", {27'd0, rpt_side, rpt_class}, 0);
         chk("R5 sticky cleared", {24'd0, src_sticky}, 0);
      end

      // R1 short pulse
      prot_lo[1] = 1'b1; tick(QUAL - 1); prot_lo = '0; tick(5);
      chk("R1 short pulse", {31'd0, fault_active}, 0);
      chk("R1 no sticky", {24'd0, src_sticky}, 0);

      // R6 blanking window
      sw_edge_hi = 1'b1; prot_hi[0] = 1'b1; tick(1);
      sw_edge_hi = 1'b0; tick(BLANK - 2);
      prot_hi = '0; tick(6);
      chk("R6 blanked desat", {31'd0, fault_active}, 0);
      // blanking does not cover the other side
      sw_edge_hi = 1'b1; prot_lo[0] = 1'b1; tick(1);
      sw_edge_hi = 1'b0; tick(QUAL + 2);
      chk("R6 other side not blanked", {31'd0, fault_active}, 1);
      prot_lo = '0; tick(2); pulse_clr(); tick(1);

      // R7 warning only
      warn_lo = 1'b1; tick(QUAL + 2);
      chk("R7 warn flag", {30'd0, ot_warn}, 2'b10);
      chk("R7 no fault", {31'd0, fault_active}, 0);
      warn_lo = 1'b0; tick(3);
      chk("R7 warn drops", {30'd0, ot_warn}, 0);

      // R11 overtemperature cool-down, latched
      prot_hi[2] = 1'b1; tick(QUAL + 2);
      chk("R11 ot class", {29'd0, rpt_class}, 3);
      prot_hi = '0; tick(5); pulse_clr(); tick(1);
      chk("R11 early clear ignored", {31'd0, fault_active}, 1);
      tick(COOL); pulse_clr(); tick(1);
      chk("R11 released after cool", {31'd0, fault_active}, 0);

      // R9 R10 auto retry
      auto_retry = 1'b1;
      for (int r = 0; r < MAXR; r++) begin
         prot_lo[1] = 1'b1; tick(QUAL + 2);
         chk("R9 retry trip", {31'd0, fault_active}, 1);
         prot_lo = '0; tick(BACKOFF - 3);
         chk("R9 waits backoff", {31'd0, fault_active}, 1);
         tick(6);
         chk("R9 auto release", {31'd0, fault_active}, 0);
      end
      prot_lo[1] = 1'b1; tick(QUAL + 2); prot_lo = '0; tick(BACKOFF + 10);
      chk("R10 capped latches", {31'd0, fault_active}, 1);
      pulse_clr(); tick(1);
      chk("R10 clear after cap", {31'd0, fault_active}, 0);
      prot_lo[1] = 1'b1; tick(QUAL + 2); prot_lo = '0; tick(BACKOFF + 4);
      chk("R10 budget restored", {31'd0, fault_active}, 0);

      // R11 in auto mode: backoff alone is not enough for OT
      prot_lo[2] = 1'b1; tick(QUAL + 2); prot_lo = '0; tick(BACKOFF + 4);
      chk("R11 ot auto waits cool", {31'd0, fault_active}, 1);
      tick(COOL);
      chk("R11 ot auto released", {31'd0, fault_active}, 0);
      chk("R12 gate back", {31'd0, gate_ok}, 1);
      supply_ok = 1'b0; tick(1);
      chk("R12 supply lost", {31'd0, gate_ok}, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule